// File: doc/BRIEF.md
# Layered Virtual-Channel Selector with Wakeup Mask

This block picks the virtual channel (VC) that a packet head takes on one output port of a mesh router, in a way that keeps unused VC buffers powered down. The VCs of the port are split into lanes. Each lane is an ordered stack of layers. A packet is placed on the lowest free layer of its lane at or above the layer it already holds, and it climbs only when the layers below it are taken. Under light traffic only the bottom layers are used, so the upper buffers can stay power-gated. The lane is chosen from the low bits of the destination number. The `LANES` parameter picks the grouping: one lane of four layers, two lanes of two, or four lanes of one.

Each cycle the allocator takes one head request with its destination, the VC the packet holds now, and a busy flag per VC from downstream. In the same cycle it returns either a grant with the chosen VC or a stall. A granted VC is then reserved until the packet's tail releases it. A per-VC wakeup mask tells the power switches which buffers must be on. The wake bit of a VC rises in the same cycle the VC is granted, so the buffer can power up while the head is still on its way.

Top module: `vc_select_alloc`

## Requirements
- R1: After the asynchronous reset (`rst_ni` low), and with no request, `grant_o` and `stall_o` are 0, `wake_o` is all zero and no VC is reserved.
- R2: With `LANES`=1, all four VCs form one lane ordered VC0 < VC1 < VC2 < VC3. A packet gets the lowest VC that is not busy and not reserved, at or above its starting VC.
- R3: With `LANES`=2, a packet with an even destination uses only VC0 then VC1, and a packet with an odd destination uses only VC2 then VC3.
- R4: With `LANES`=4, a packet uses only VC number (destination mod 4).
- R5: The starting VC is `cur_vc_i` when that VC lies in the packet's lane; otherwise it is the bottom VC of the lane (VC0 at injection). A grant is never below the starting VC.
- R6: When a request finds no usable VC in its lane at or above its start, `stall_o` is 1 and `grant_o` is 0. There is no wrap to a lower VC and no use of another lane. `grant_o` and `stall_o` are both 0 when there is no request.
- R7: `wake_o[v]` is 1 in the same cycle VC v is granted. It stays 1 until the clock edge where a release of v is taken while `vc_busy_i[v]` is low.
- R8: A granted VC is reserved, and counts as unavailable, until `release_i` with `release_vc_i` naming it is taken on a clock edge. After that it can be granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A packet head requests a VC this cycle |
| dst_i | input | DST_W | Destination number of the requesting packet |
| cur_vc_i | input | log2(NUM_VC) | VC the packet occupies now (0 at injection) |
| vc_busy_i | input | NUM_VC | Downstream occupancy flag per VC |
| release_i | input | 1 | The tail of a packet leaves, freeing one reserved VC |
| release_vc_i | input | log2(NUM_VC) | VC freed by the tail |
| grant_o | output | 1 | A VC was chosen for the request |
| grant_vc_o | output | log2(NUM_VC) | Chosen VC (0 when no grant) |
| stall_o | output | 1 | Request present but no usable VC |
| wake_o | output | NUM_VC | Per-VC power-on request |

## Verification
All three grouping modes are driven with the same kinds of patterns. Idle ports show the lane split by even and odd or by modulo destination. Growing busy masks show the climb order and the point where the allocator stalls instead of wrapping. A starting VC inside the lane is checked against one outside it, which tells apart the no-descent rule and the fall back to the bottom layer. Back-to-back heads without releases then show that reservations, and not only the busy flags, push later packets upward. A release brings the freed VC back down to the bottom choice, and the wake mask is checked on the grant cycle, while the VC is held, and after the release.

// File: rtl/vc_alloc_pkg.sv
package vc_alloc_pkg;
  localparam int unsigned DEF_NUM_VC = 4;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_DST_W  = 6;

  // first VC index of the lane owned by a destination
  function automatic int unsigned lane_base(input int unsigned dst,
                                            input int unsigned lanes,
                                            input int unsigned depth);
    return (dst % lanes) * depth;
  endfunction
endpackage

// File: rtl/vc_lane_map.sv
module vc_lane_map
  import vc_alloc_pkg::*;
#(
  parameter int unsigned NUM_VC = DEF_NUM_VC,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned DST_W  = DEF_DST_W,
  localparam int unsigned VC_W  = $clog2(NUM_VC),
  localparam int unsigned DEPTH = NUM_VC / LANES
) (
  input  logic [DST_W-1:0]  dst_i,
  input  logic [VC_W-1:0]   cur_vc_i,
  output logic [NUM_VC-1:0] lane_mask_o,
  output logic [VC_W-1:0]   start_vc_o
);
  int unsigned base;
  int unsigned cur;

  always_comb begin
    base = lane_base(32'(dst_i), LANES, DEPTH);
    cur  = 32'(cur_vc_i);
    for (int unsigned v = 0; v < NUM_VC; v++) begin
      lane_mask_o[v] = (v >= base) && (v < base + DEPTH);
    end
    // a packet already inside its lane never descends; else enter at the bottom layer
    if ((cur >= base) && (cur < base + DEPTH)) start_vc_o = cur_vc_i;
    else                                       start_vc_o = VC_W'(base);
  end
endmodule

// File: rtl/vc_pick.sv
module vc_pick #(
  parameter int unsigned NUM_VC = 4,
  localparam int unsigned VC_W  = $clog2(NUM_VC)
) (
  input  logic [NUM_VC-1:0] avail_i,
  input  logic [VC_W-1:0]   start_vc_i,
  output logic              found_o,
  output logic [VC_W-1:0]   pick_vc_o
);
  always_comb begin
    found_o   = 1'b0;
    pick_vc_o = '0;
    // descending scan: the lowest eligible layer is written last
    for (int v = NUM_VC - 1; v >= 0; v--) begin
      if (avail_i[v] && (v >= int'(start_vc_i))) begin
        found_o   = 1'b1;
        pick_vc_o = VC_W'(v);
      end
    end
  end
endmodule

// File: rtl/vc_hold_state.sv
module vc_hold_state #(
  parameter int unsigned NUM_VC = 4,
  localparam int unsigned VC_W  = $clog2(NUM_VC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  logic [VC_W-1:0]   grant_vc_i,
  input  logic              release_i,
  input  logic [VC_W-1:0]   release_vc_i,
  input  logic [NUM_VC-1:0] vc_busy_i,
  output logic [NUM_VC-1:0] held_o,
  output logic [NUM_VC-1:0] awake_o
);
  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic set_vc, clr_vc;
    assign set_vc = grant_i && (grant_vc_i == VC_W'(v));
    assign clr_vc = release_i && (release_vc_i == VC_W'(v));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        held_o[v]  <= 1'b0;
        awake_o[v] <= 1'b0;
      end else begin
        if (set_vc)      held_o[v] <= 1'b1;
        else if (clr_vc) held_o[v] <= 1'b0;
        // stays powered while reserved or while downstream still holds flits
        awake_o[v] <= set_vc || (held_o[v] && !clr_vc) || vc_busy_i[v];
      end
    end
  end
endmodule

// File: rtl/vc_select_alloc.sv
module vc_select_alloc
  import vc_alloc_pkg::*;
#(
  parameter int unsigned NUM_VC = DEF_NUM_VC,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned DST_W  = DEF_DST_W,
  localparam int unsigned VC_W  = $clog2(NUM_VC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [DST_W-1:0]  dst_i,
  input  logic [VC_W-1:0]   cur_vc_i,
  input  logic [NUM_VC-1:0] vc_busy_i,
  input  logic              release_i,
  input  logic [VC_W-1:0]   release_vc_i,
  output logic              grant_o,
  output logic [VC_W-1:0]   grant_vc_o,
  output logic              stall_o,
  output logic [NUM_VC-1:0] wake_o
);
  logic [NUM_VC-1:0] lane_mask;
  logic [VC_W-1:0]   start_vc;
  logic [NUM_VC-1:0] held_q;
  logic [NUM_VC-1:0] awake_q;
  logic [NUM_VC-1:0] avail;
  logic [NUM_VC-1:0] grant_oh;
  logic              found;
  logic [VC_W-1:0]   pick_vc;

  vc_lane_map #(.NUM_VC(NUM_VC), .LANES(LANES), .DST_W(DST_W)) u_map (
    .dst_i       (dst_i),
    .cur_vc_i    (cur_vc_i),
    .lane_mask_o (lane_mask),
    .start_vc_o  (start_vc)
  );

  assign avail = lane_mask & ~vc_busy_i & ~held_q;

  vc_pick #(.NUM_VC(NUM_VC)) u_pick (
    .avail_i    (avail),
    .start_vc_i (start_vc),
    .found_o    (found),
    .pick_vc_o  (pick_vc)
  );

  assign grant_o    = req_valid_i && found;
  assign stall_o    = req_valid_i && !found;
  assign grant_vc_o = grant_o ? pick_vc : '0;

  vc_hold_state #(.NUM_VC(NUM_VC)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .grant_i      (grant_o),
    .grant_vc_i   (grant_vc_o),
    .release_i    (release_i),
    .release_vc_i (release_vc_i),
    .vc_busy_i    (vc_busy_i),
    .held_o       (held_q),
    .awake_o      (awake_q)
  );

  for (genvar v = 0; v < NUM_VC; v++) begin : g_oh
    assign grant_oh[v] = grant_o && (pick_vc == VC_W'(v));
  end

  // wake in the grant cycle itself, ahead of the registered state
  assign wake_o = awake_q | grant_oh;
endmodule

// File: rtl/vc_alloc_checker.sv
module vc_alloc_checker #(
  parameter int unsigned NUM_VC = 4,
  parameter int unsigned LANES  = 2,
  parameter int unsigned DST_W  = 6,
  localparam int unsigned VC_W  = $clog2(NUM_VC),
  localparam int unsigned DEPTH = NUM_VC / LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [DST_W-1:0]  dst_i,
  input logic [VC_W-1:0]   cur_vc_i,
  input logic [NUM_VC-1:0] vc_busy_i,
  input logic              grant_o,
  input logic [VC_W-1:0]   grant_vc_o,
  input logic              stall_o,
  input logic [NUM_VC-1:0] wake_o,
  input logic [NUM_VC-1:0] held_i
);
  logic lane_ok;
  logic cur_in_lane;

  always_comb begin
    lane_ok     = (int'(grant_vc_o) / int'(DEPTH)) == (int'(dst_i) % int'(LANES));
    cur_in_lane = (int'(cur_vc_i) / int'(DEPTH)) == (int'(dst_i) % int'(LANES));
  end

  AST_GRANT_XOR_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (grant_o ^ stall_o)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!grant_o && !stall_o)); // R6
  AST_GRANT_IN_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> lane_ok); // R3
  AST_NO_DESCENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && cur_in_lane) |-> (grant_vc_o >= cur_vc_i)); // R5
  AST_GRANT_FREE_VC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (!vc_busy_i[grant_vc_o] && !held_i[grant_vc_o])); // R8
  AST_WAKE_ON_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> wake_o[grant_vc_o]); // R7
  AST_WAKE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> wake_o[$past(grant_vc_o)]); // R7
endmodule

bind vc_select_alloc vc_alloc_checker #(
  .NUM_VC (NUM_VC),
  .LANES  (LANES),
  .DST_W  (DST_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .dst_i       (dst_i),
  .cur_vc_i    (cur_vc_i),
  .vc_busy_i   (vc_busy_i),
  .grant_o     (grant_o),
  .grant_vc_o  (grant_vc_o),
  .stall_o     (stall_o),
  .wake_o      (wake_o),
  .held_i      (held_q)
);

// File: tb/vc_select_alloc_test.sv
module vc_select_alloc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // index 0: LANES=2 (uut), 1: LANES=1, 2: LANES=4
  logic       req  [3];
  logic [5:0] dst  [3];
  logic [1:0] cur  [3];
  logic [3:0] busy [3];
  logic       rel  [3];
  logic [1:0] rvc  [3];
  logic       gnt  [3];
  logic [1:0] gvc  [3];
  logic       stl  [3];
  logic [3:0] wk   [3];

  vc_select_alloc #(.NUM_VC(4), .LANES(2), .DST_W(6)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req[0]), .dst_i(dst[0]), .cur_vc_i(cur[0]),
    .vc_busy_i(busy[0]), .release_i(rel[0]), .release_vc_i(rvc[0]),
    .grant_o(gnt[0]), .grant_vc_o(gvc[0]), .stall_o(stl[0]), .wake_o(wk[0]));
  vc_select_alloc #(.NUM_VC(4), .LANES(1), .DST_W(6)) uut_l1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req[1]), .dst_i(dst[1]), .cur_vc_i(cur[1]),
    .vc_busy_i(busy[1]), .release_i(rel[1]), .release_vc_i(rvc[1]),
    .grant_o(gnt[1]), .grant_vc_o(gvc[1]), .stall_o(stl[1]), .wake_o(wk[1]));
  vc_select_alloc #(.NUM_VC(4), .LANES(4), .DST_W(6)) uut_l4 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req[2]), .dst_i(dst[2]), .cur_vc_i(cur[2]),
    .vc_busy_i(busy[2]), .release_i(rel[2]), .release_vc_i(rvc[2]),
    .grant_o(gnt[2]), .grant_vc_o(gvc[2]), .stall_o(stl[2]), .wake_o(wk[2]));

  typedef struct packed {
    logic [1:0] k;
    logic [5:0] dst;
    logic [1:0] cur;
    logic [3:0] busy;
    logic       g;
    logic [1:0] vc;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 6'd4, 2'd0, 4'b0000, 1'b1, 2'd0, 4'd3},  // R3 even -> VC0
    '{2'd0, 6'd5, 2'd0, 4'b0000, 1'b1, 2'd2, 4'd3},  // R3 odd -> VC2
    '{2'd0, 6'd4, 2'd0, 4'b0001, 1'b1, 2'd1, 4'd3},  // R3 even climbs to VC1
    '{2'd0, 6'd5, 2'd0, 4'b0100, 1'b1, 2'd3, 4'd3},  // R3 odd climbs to VC3
    '{2'd0, 6'd4, 2'd0, 4'b0011, 1'b0, 2'd0, 4'd6},  // R6 even lane full, no other lane
    '{2'd0, 6'd5, 2'd0, 4'b1100, 1'b0, 2'd0, 4'd6},  // R6 odd lane full
    '{2'd0, 6'd4, 2'd1, 4'b0000, 1'b1, 2'd1, 4'd5},  // R5 stays on VC1
    '{2'd0, 6'd5, 2'd3, 4'b0000, 1'b1, 2'd3, 4'd5},  // R5 stays on VC3
    '{2'd0, 6'd5, 2'd3, 4'b1000, 1'b0, 2'd0, 4'd6},  // R6 no wrap down to VC2
    '{2'd0, 6'd4, 2'd2, 4'b0000, 1'b1, 2'd0, 4'd5},  // R5 start outside lane -> bottom
    '{2'd1, 6'd7, 2'd0, 4'b0000, 1'b1, 2'd0, 4'd2},  // R2 VC0 first
    '{2'd1, 6'd7, 2'd0, 4'b0111, 1'b1, 2'd3, 4'd2},  // R2 climbs to VC3
    '{2'd1, 6'd7, 2'd2, 4'b0000, 1'b1, 2'd2, 4'd2},  // R2 starts at current VC2
    '{2'd1, 6'd7, 2'd1, 4'b1110, 1'b0, 2'd0, 4'd6},  // R6 VC0 free but below start
    '{2'd2, 6'd6, 2'd0, 4'b0000, 1'b1, 2'd2, 4'd4},  // R4 6 mod 4
    '{2'd2, 6'd7, 2'd0, 4'b0000, 1'b1, 2'd3, 4'd4},  // R4 7 mod 4
    '{2'd2, 6'd9, 2'd0, 4'b0000, 1'b1, 2'd1, 4'd4},  // R4 9 mod 4
    '{2'd2, 6'd6, 2'd0, 4'b0100, 1'b0, 2'd0, 4'd4},  // R4 own VC busy -> stall
    '{2'd2, 6'd8, 2'd3, 4'b0000, 1'b1, 2'd0, 4'd4}   // R4 current VC ignored
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    for (int k = 0; k < 3; k++) begin
      req[k] = 1'b0; dst[k] = '0; cur[k] = '0; busy[k] = '0; rel[k] = 1'b0; rvc[k] = '0;
    end
  endtask

  // request, check same cycle, check after edge, release, check wake cleared
  task automatic run_vec(input vec_t v);
    int k;
    string tg;
    k  = int'(v.k);
    tg = $sformatf("R%0d inst%0d dst%0d", v.rq, k, v.dst);
    @(negedge clk);
    req[k] = 1'b1; dst[k] = v.dst; cur[k] = v.cur; busy[k] = v.busy;
    #1;
    check(gnt[k] == v.g, {tg, " grant"}, int'(gnt[k]), int'(v.g));
    check(stl[k] == !v.g, {tg, " stall"}, int'(stl[k]), int'(!v.g));
    if (v.g) begin
      check(gvc[k] == v.vc, {tg, " vc"}, int'(gvc[k]), int'(v.vc));
      check(wk[k][v.vc], {"R7 wake same cycle ", tg}, int'(wk[k]), 1 << v.vc);
    end
    @(negedge clk);
    req[k] = 1'b0; busy[k] = '0;
    if (v.g) begin
      rel[k] = 1'b1; rvc[k] = v.vc;
      #1;
      check(wk[k][v.vc], {"R7 wake held ", tg}, int'(wk[k]), 1 << v.vc);
    end
    @(negedge clk);
    rel[k] = 1'b0;
    #1;
    check(wk[k] == 4'b0000, {"R7 wake off after release ", tg}, int'(wk[k]), 0);
  endtask

  task automatic head0(input logic [5:0] d, input bit eg, input logic [1:0] evc, input string tg);
    @(negedge clk);
    req[0] = 1'b1; dst[0] = d; cur[0] = '0; busy[0] = '0;
    #1;
    check(gnt[0] == eg, {tg, " grant"}, int'(gnt[0]), int'(eg));
    if (eg) check(gvc[0] == evc, {tg, " vc"}, int'(gvc[0]), int'(evc));
    @(negedge clk);
    req[0] = 1'b0;
  endtask

  initial begin
    idle_all();
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < 3; k++) begin
      check(gnt[k] == 1'b0, "R1 grant in reset", int'(gnt[k]), 0);
      check(wk[k] == 4'b0000, "R1 wake in reset", int'(wk[k]), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    for (int k = 0; k < 3; k++) begin
      check(gnt[k] == 1'b0 && stl[k] == 1'b0, "R1 idle after reset", int'(stl[k]), 0);
      check(wk[k] == 4'b0000, "R1 wake after reset", int'(wk[k]), 0);
    end

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8: reservations push later heads upward until released
    head0(6'd4, 1'b1, 2'd0, "R8 first even head");
    head0(6'd2, 1'b1, 2'd1, "R8 second even head skips held VC0");
    head0(6'd0, 1'b0, 2'd0, "R8 third even head stalls");
    #1;
    check(wk[0] == 4'b0011, "R7 wake covers both held VCs", int'(wk[0]), 3);
    head0(6'd3, 1'b1, 2'd2, "R8 odd lane unaffected");
    @(negedge clk);
    rel[0] = 1'b1; rvc[0] = 2'd0;
    @(negedge clk);
    rel[0] = 1'b0;
    #1;
    check(wk[0] == 4'b0110, "R7 VC0 asleep after its release", int'(wk[0]), 6);
    head0(6'd8, 1'b1, 2'd0, "R8 released VC0 granted again");
    head0(6'd1, 1'b1, 2'd3, "R8 odd climbs over held VC2");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule